// File: doc/BRIEF.md
# Interrupt Line Enable and Priority Register Bank

This block is the software-visible configuration store that sits in front of an interrupt arbiter. It keeps one enable flag and one priority level per external interrupt line, and a single priority-grouping value that tells the arbiter where the split between pre-emption and sub-priority lies. Software reaches it through a word-addressed read/write port. The block hands the stored state to the arbiter as flat vectors. It also shows the arbiter's per-line pending flags back to software.

Enable flags cannot be written directly. Each enable word has two windows. In the first, a one bit turns a line on. In the second, a one bit turns it off. Zero bits in either window leave the line alone, so no read-modify-write is needed. Priority bytes carry four lines per word, and byte strobes select which of them a write touches. Only the upper four bits of each byte are kept. The grouping field changes only when the write carries a fixed key in its upper half. Raw requests from peripherals are masked by the enable flags before they leave the block.

Top module: `irq_cfg_regs`

## Requirements
- R1: On reset all enable flags, all priority levels and the grouping field are zero, and the control word at word address 0x60 reads 0xFA050000.
- R2: A write to set-window word w (word address 0x00+w) enables line 32*w+b for every bit b that is 1.
- R3: A write to clear-window word w (word address 0x08+w) disables line 32*w+b for every bit b that is 1.
- R4: Zero bits in a set-window or clear-window write leave the enable flags unchanged. A read of either window returns the current enable flags of that word.
- R5: Priority word k (word address 0x20+k) holds lines 4k to 4k+3, with line 4k+j in byte j (bits 8j+7 to 8j). A write updates byte j only when bus_be[j] is 1. Only bits 8j+7 to 8j+4 are stored, and bits 8j+3 to 8j read as zero.
- R6: line_prio carries the stored 4-bit level of line n at bits 4n+3 to 4n.
- R7: The grouping field is bits 10 to 8 of the control word. It is updated only when bits 31 to 16 of the write equal 0x05FA. The control word reads back as 0xFA05 in bits 31 to 16, the grouping field in bits 10 to 8, and zeros elsewhere.
- R8: line_req_o[n] is 1 only when line_req_i[n] is 1 and line n is enabled.
- R9: Pending word w (word address 0x10+w) reads line_pending for lines 32*w to 32*w+31. Writes to it have no effect.
- R10: Bits and bytes that map to lines at or above NUM_LINES read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, used by priority words |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| line_pending | input | NUM_LINES | Pending flags from the arbiter |
| line_req_i | input | NUM_LINES | Raw peripheral requests |
| line_req_o | output | NUM_LINES | Requests masked by the enable flags |
| line_en | output | NUM_LINES | Enable flag per line |
| line_prio | output | NUM_LINES*PRIO_W | Priority level per line |
| prio_group | output | 3 | Priority-grouping value |

## Verification
The assertions assume that a bus access is held stable across the clock edge that samples it. They also assume that bus_sel, bus_wr and bus_addr never carry unknown values after reset. The bench meets both by changing bus signals only on the falling edge and by parking the port with bus_sel low between accesses. Line 0 is the line the enable properties watch. The stimulus writes and clears its bit through both windows, and it also writes zero words to those windows, so the properties are exercised in both directions.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 6;
  localparam int SET_BASE  = 'h00;
  localparam int CLR_BASE  = 'h08;
  localparam int PEND_BASE = 'h10;
  localparam int PRIO_BASE = 'h20;
  localparam int CTRL_ADDR = 'h60;
  localparam int EN_SPAN   = 8;
  localparam int PRIO_SPAN = 64;
  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;

  typedef enum logic [2:0] {
    REG_NONE, REG_SET, REG_CLR, REG_PEND, REG_PRIO, REG_CTRL
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_cfg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  int a;
  always_comb begin
    a     = int'(addr_i);
    sel_o = REG_NONE;
    idx_o = '0;
    if (a >= SET_BASE && a < SET_BASE + EN_SPAN) begin
      sel_o = REG_SET;
      idx_o = IDX_W'(a - SET_BASE);
    end else if (a >= CLR_BASE && a < CLR_BASE + EN_SPAN) begin
      sel_o = REG_CLR;
      idx_o = IDX_W'(a - CLR_BASE);
    end else if (a >= PEND_BASE && a < PEND_BASE + EN_SPAN) begin
      sel_o = REG_PEND;
      idx_o = IDX_W'(a - PEND_BASE);
    end else if (a >= PRIO_BASE && a < PRIO_BASE + PRIO_SPAN) begin
      sel_o = REG_PRIO;
      idx_o = IDX_W'(a - PRIO_BASE);
    end else if (a == CTRL_ADDR) begin
      sel_o = REG_CTRL;
    end
  end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank
  import irq_cfg_pkg::*;
#(
  parameter int NUM_LINES = 68
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NUM_LINES-1:0] en_q
);
  logic [NUM_LINES-1:0] en_d;
  logic                 en_load;

  assign en_load = set_we | clr_we;

  // Set and clear windows sit at different addresses, so never both at once.
  always_comb begin
    en_d = en_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (idx == IDX_W'(i / WORD_W) && wdata[i % WORD_W]) begin
        if (set_we) en_d[i] = 1'b1;
        if (clr_we) en_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_load) en_q <= en_d;
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_cfg_pkg::*;
#(
  parameter int NUM_LINES = 68,
  parameter int PRIO_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [3:0]                  be,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_LINES*PRIO_W-1:0] prio_q
);
  localparam int LPW = WORD_W / 8;   // lines per priority word

  logic [NUM_LINES*PRIO_W-1:0] prio_d;

  // Each byte keeps only its top PRIO_W bits (MSB aligned).
  always_comb begin
    prio_d = prio_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (idx == IDX_W'(i / LPW) && be[i % LPW])
        prio_d[i*PRIO_W +: PRIO_W] = wdata[(i % LPW)*8 + 8 - PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prio_q <= '0;
    else if (we) prio_q <= prio_d;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_cfg_pkg::*;
#(
  parameter int NUM_LINES = 68,
  parameter int PRIO_W    = 4,
  parameter int ADDR_W    = 7
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic [3:0]                  bus_be,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_LINES-1:0]        line_pending,
  input  logic [NUM_LINES-1:0]        line_req_i,
  output logic [NUM_LINES-1:0]        line_req_o,
  output logic [NUM_LINES-1:0]        line_en,
  output logic [NUM_LINES*PRIO_W-1:0] line_prio,
  output logic [2:0]                  prio_group
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  reg_sel_e         dsel;
  logic [IDX_W-1:0] didx;
  logic             wr_act;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .sel_o  (dsel),
    .idx_o  (didx)
  );

  assign wr_act = bus_sel & bus_wr;

  irq_en_bank #(.NUM_LINES(NUM_LINES)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_act && dsel == REG_SET),
    .clr_we (wr_act && dsel == REG_CLR),
    .idx    (didx),
    .wdata  (bus_wdata),
    .en_q   (line_en)
  );

  irq_prio_bank #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_act && dsel == REG_PRIO),
    .idx    (didx),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .prio_q (line_prio)
  );

  // Grouping field, key protected.
  logic       grp_we;
  logic [2:0] grp_d;
  assign grp_we = wr_act && dsel == REG_CTRL && bus_wdata[31:16] == WR_KEY;
  assign grp_d  = bus_wdata[10:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prio_group <= 3'd0;
    else if (grp_we) prio_group <= grp_d;
  end

  assign line_req_o = line_req_i & line_en;

  // Read-back mux
  always_comb begin
    bus_rdata = '0;
    unique case (dsel)
      REG_SET, REG_CLR: begin
        for (int b = 0; b < WORD_W; b++)
          if (int'(didx) * WORD_W + b < NUM_LINES)
            bus_rdata[b] = line_en[int'(didx) * WORD_W + b];
      end
      REG_PEND: begin
        for (int b = 0; b < WORD_W; b++)
          if (int'(didx) * WORD_W + b < NUM_LINES)
            bus_rdata[b] = line_pending[int'(didx) * WORD_W + b];
      end
      REG_PRIO: begin
        for (int j = 0; j < 4; j++)
          if (int'(didx) * 4 + j < NUM_LINES)
            bus_rdata[8*j + 8 - PRIO_W +: PRIO_W] =
              line_prio[(int'(didx) * 4 + j) * PRIO_W +: PRIO_W];
      end
      REG_CTRL: bus_rdata = {RD_KEY, 5'd0, prio_group, 8'd0};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cfg_chk.sv
module irq_cfg_chk
  import irq_cfg_pkg::*;
#(
  parameter int NUM_LINES = 68,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] line_en,
  input logic [2:0]           prio_group
);
  logic wr_set0, wr_clr0, wr_ctrl, rd_prio;
  assign wr_set0 = bus_sel && bus_wr && bus_addr == ADDR_W'(SET_BASE);
  assign wr_clr0 = bus_sel && bus_wr && bus_addr == ADDR_W'(CLR_BASE);
  assign wr_ctrl = bus_sel && bus_wr && bus_addr == ADDR_W'(CTRL_ADDR);
  assign rd_prio = bus_sel && !bus_wr && int'(bus_addr) >= PRIO_BASE
                   && int'(bus_addr) < PRIO_BASE + PRIO_SPAN;

  a_r2_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set0 && bus_wdata[0]) |=> line_en[0]);

  a_r3_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr0 && bus_wdata[0]) |=> !line_en[0]);

  a_r4_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_set0 || wr_clr0) && bus_wdata[0]) |=> $stable(line_en[0]));

  a_r7_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[31:16] != WR_KEY) |=> $stable(prio_group));

  a_r5_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_prio |-> (bus_rdata[3:0] == 4'd0 && bus_rdata[11:8] == 4'd0 &&
                 bus_rdata[19:16] == 4'd0 && bus_rdata[27:24] == 4'd0));
endmodule

bind irq_cfg_regs irq_cfg_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .line_en    (line_en),
  .prio_group (prio_group)
);

// File: tb/sim_irq_cfg_regs.sv
module sim_irq_cfg_regs;
  localparam int N  = 68;
  localparam int PW = 4;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [3:0]    bus_be;
  logic [N-1:0]  line_pending, line_req_i, line_req_o, line_en;
  logic [N*PW-1:0] line_prio;
  logic [2:0]    prio_group;

  always #5 clk = ~clk;

  irq_cfg_regs #(.NUM_LINES(N), .PRIO_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_ni(rst_ni), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .line_pending(line_pending),
    .line_req_i(line_req_i), .line_req_o(line_req_o), .line_en(line_en),
    .line_prio(line_prio), .prio_group(prio_group)
  );

  typedef struct packed {
    logic        rd;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  // Tags exercised by the table: R2 R3 R4 R5 R7 R9 R10
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h00, 32'h0000_0005, 4'hF, 32'h0,          4'd2},
    '{1'b1, 7'h00, 32'h0,         4'h0, 32'h0000_0005,  4'd2},
    '{1'b1, 7'h08, 32'h0,         4'h0, 32'h0000_0005,  4'd4},
    '{1'b0, 7'h08, 32'h0000_0001, 4'hF, 32'h0,          4'd3},
    '{1'b1, 7'h00, 32'h0,         4'h0, 32'h0000_0004,  4'd3},
    '{1'b0, 7'h00, 32'h0,         4'hF, 32'h0,          4'd4},
    '{1'b0, 7'h08, 32'h0,         4'hF, 32'h0,          4'd4},
    '{1'b1, 7'h08, 32'h0,         4'h0, 32'h0000_0004,  4'd4},
    '{1'b0, 7'h02, 32'hFFFF_FFFF, 4'hF, 32'h0,          4'd10},
    '{1'b1, 7'h02, 32'h0,         4'h0, 32'h0000_000F,  4'd10},
    '{1'b0, 7'h20, 32'hF1A2_5B37, 4'hF, 32'h0,          4'd5},
    '{1'b1, 7'h20, 32'h0,         4'h0, 32'hF0A0_5030,  4'd5},
    '{1'b0, 7'h20, 32'h0000_C000, 4'h2, 32'h0,          4'd5},
    '{1'b1, 7'h20, 32'h0,         4'h0, 32'hF0A0_C030,  4'd5},
    '{1'b0, 7'h30, 32'h8800_0090, 4'hF, 32'h0,          4'd5},
    '{1'b1, 7'h30, 32'h0,         4'h0, 32'h8000_0090,  4'd5},
    '{1'b0, 7'h31, 32'hFFFF_FFFF, 4'hF, 32'h0,          4'd10},
    '{1'b1, 7'h31, 32'h0,         4'h0, 32'h0,          4'd10},
    '{1'b0, 7'h60, 32'h0000_0500, 4'hF, 32'h0,          4'd7},
    '{1'b1, 7'h60, 32'h0,         4'h0, 32'hFA05_0000,  4'd7},
    '{1'b0, 7'h60, 32'h05FA_0500, 4'hF, 32'h0,          4'd7},
    '{1'b1, 7'h60, 32'h0,         4'h0, 32'hFA05_0500,  4'd7},
    '{1'b0, 7'h10, 32'hFFFF_FFFF, 4'hF, 32'h0,          4'd9},
    '{1'b1, 7'h10, 32'h0,         4'h0, 32'h8000_0001,  4'd9},
    '{1'b1, 7'h12, 32'h0,         4'h0, 32'h0000_0009,  4'd9}
  };

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'h0;
    #1 d = bus_rdata;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_ni = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_be = '0; line_req_i = '0;
    line_pending = {4'h9, 32'h0, 32'h8000_0001};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 en", 96'(line_en), 96'h0);
    check("R1 prio", 96'(line_prio[95:0]), 96'h0);
    check("R1 group", 96'(prio_group), 96'h0);
    bus_read(7'h60, rd);
    check("R1 ctrl", 96'(rd), 96'hFA05_0000);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].rd) begin
        bus_read(VECS[v].addr, rd);
        check($sformatf("R%0d vec %0d", VECS[v].req, v), 96'(rd), 96'(VECS[v].exp));
      end else begin
        bus_write(VECS[v].addr, VECS[v].data, VECS[v].be);
      end
    end
    @(negedge clk); bus_sel = 1'b0;
    #1;

    // R6: per-line priority outputs
    check("R6 lines0-3", 96'(line_prio[15:0]), 96'hFAC3);
    check("R6 lines64-67", 96'(line_prio[64*PW +: 16]), 96'h8009);
    // R7: grouping output
    check("R7 group", 96'(prio_group), 96'h5);
    // R10 / R2: enabled set is line 2 and lines 64..67
    check("R10 en", 96'(line_en), 96'(68'hF_0000_0000_0000_0004));
    // R8: request masking
    line_req_i = '1; #1;
    check("R8 all req", 96'(line_req_o), 96'(68'hF_0000_0000_0000_0004));
    line_req_i = 68'h0_0000_0000_0000_0003; #1;
    check("R8 partial", 96'(line_req_o), 96'h0);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_ni = 1'b0; #1;
    check("R1 async en", 96'(line_en), 96'h0);
    check("R1 async group", 96'(prio_group), 96'h0);
    check("R1 async prio", 96'(line_prio[95:0]), 96'h0);
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(7'h00, rd);
    check("R1 after reset set-window", 96'(rd), 96'h0);
    @(negedge clk); bus_sel = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule